// File: doc/BRIEF.md
# Display Scan Line and Drive Level Generator

This block sequences the row scan of a passive-matrix display of 104 dot rows plus one icon row. A host writes a start-line value; each frame sync copies it into a line counter that advances once per line-clock pulse, and the counter is the RAM row address whose segment data are latched for that line. After the last dot row the block addresses the fixed icon row, whatever the start line is, and then idles until the next frame sync. Rewriting the start line between frames scrolls the picture without touching RAM.

The block also produces the AC polarity signal and maps every segment bit and every common row to an encoded drive level. The mapping depends on the data bit, the polarity and four modes: display off, reverse, entire-display-on and power save. Sequencing uses four named states. IDLE (after reset) goes to SCAN on frame sync. SCAN goes to ICON on the line pulse that ends dot row 103. ICON goes to WAIT on the next line pulse. Any state goes to SCAN on frame sync.

Top module: `lcd_scan_drive`

## Requirements
- R1: The start-line register resets to 0. It is loaded from `start_val` when `start_wr` is high and `start_val` < 104. A write of 104 or more is ignored and the old value is kept.
- R2: A cycle with `frame_sync` high gives, from the next cycle on, `row_valid`=1, `com_ptr`=0 and `row_addr` equal to the start-line value held before that edge. A write in the same cycle takes effect at the following frame. Frame sync wins over a line pulse in the same cycle.
- R3: During the dot scan, each `line_clk` pulse advances `com_ptr` by one and `row_addr` by one, and `row_addr` wraps from 103 to 0.
- R4: The pulse that ends dot row 103 (the 104th after frame sync) gives `row_addr`=104 and `com_ptr`=104, whatever the start line is. The next pulse drops `row_valid` to 0 until the next frame sync.
- R5: Level codes are Vss=0, V4=1, V3=2, V2=3, V1=4, V0=5, three bits per output, with segment i at bits [3i+2:3i]. In normal display a segment with data 1 gives V0 when `m_pol` is 1 and Vss when it is 0. A segment with data 0 gives V2 when `m_pol` is 1 and V3 when it is 0.
- R6: With `reverse_on`, the data sense is inverted before the R5 mapping.
- R7: With `all_on`, every segment is treated as data 1, and this takes priority over reverse.
- R8: With `disp_on` low, every segment is treated as data 0 and no common row is selected.
- R9: Common row i, at `com_lvl` bits [3i+2:3i], is selected when `row_valid` is 1 and `com_ptr`=i. A selected row gives Vss when `m_pol` is 1 and V0 when it is 0. An unselected row gives V1 when `m_pol` is 1 and V4 when it is 0.
- R10: `power_save` drives every segment and common code to Vss (0) and overrides all other modes.
- R11: With `m_line_mode` low, `m_pol` inverts on each frame sync and at no other time.
- R12: With `m_line_mode` high, `m_pol` inverts on every N-th line pulse after IDLE, where N=`m_line_n` and 0 counts as 1. Frame sync clears the count without inverting.
- R13: After reset, `row_valid`, `row_addr`, `com_ptr` and `m_pol` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_clk | input | 1 | One-cycle line clock pulse |
| frame_sync | input | 1 | One-cycle frame start pulse |
| start_wr | input | 1 | Start-line write strobe |
| start_val | input | 7 | Start-line write value |
| disp_on | input | 1 | Display enable |
| reverse_on | input | 1 | Reverse display |
| all_on | input | 1 | Entire display on |
| power_save | input | 1 | Power save, all outputs at Vss |
| m_line_mode | input | 1 | Polarity inverts every N lines instead of per frame |
| m_line_n | input | 4 | Line count N for line-based polarity |
| seg_data | input | 160 | RAM row data for the addressed line |
| row_addr | output | 7 | RAM line address |
| row_valid | output | 1 | A row is being scanned |
| com_ptr | output | 7 | Common row being driven |
| m_pol | output | 1 | AC polarity |
| seg_lvl | output | 480 | Segment level codes |
| com_lvl | output | 315 | Common level codes |

## Verification
Frame sync can arrive in the same cycle as a line pulse and a start-line write. The bench drives all three on one edge. It expects the counter to restart at the old start line with the pointer at row 0, the line pulse to be dropped, and the new start line to show only at the next frame. In line-polarity mode the bench also checks that a frame sync in the same cycle as the N-th pulse clears the count and does not invert the polarity.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
    typedef enum logic [2:0] {
        LV_VSS = 3'd0,
        LV_V4  = 3'd1,
        LV_V3  = 3'd2,
        LV_V2  = 3'd3,
        LV_V1  = 3'd4,
        LV_V0  = 3'd5
    } lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_ICON = 2'd2,
        ST_WAIT = 2'd3
    } scan_st_e;

    localparam int LVL_W = 3;
endpackage

// File: rtl/lsd_scan_seq.sv
module lsd_scan_seq
    import lsd_pkg::*;
#(
    parameter int DOT_ROWS = 104,
    parameter int LW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_clk,
    input  logic          frame_sync,
    input  logic          start_wr,
    input  logic [LW-1:0] start_val,
    output logic [LW-1:0] row_addr,
    output logic [LW-1:0] com_ptr,
    output logic          row_valid,
    output logic          cl_step
);
    localparam logic [LW-1:0] LAST_DOT = LW'(DOT_ROWS - 1);
    localparam logic [LW-1:0] ICON_ROW = LW'(DOT_ROWS);

    scan_st_e      st_q, st_d;
    logic [LW-1:0] start_q;
    logic [LW-1:0] line_q, ptr_q;
    logic          adv;

    assign adv     = line_clk && !frame_sync;
    assign cl_step = adv && (st_q != ST_IDLE);

    // start-line register, writes beyond the dot area are dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (start_wr && (start_val < ICON_ROW)) begin
            start_q <= start_val;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (frame_sync) begin
            st_d = ST_SCAN;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_SCAN: if (adv && ptr_q == LAST_DOT) st_d = ST_ICON;
                ST_ICON: if (adv) st_d = ST_WAIT;
                ST_WAIT: st_d = ST_WAIT;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // line counter and common pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            ptr_q  <= '0;
        end else if (frame_sync) begin
            line_q <= start_q;
            ptr_q  <= '0;
        end else if (adv && st_q == ST_SCAN) begin
            if (ptr_q == LAST_DOT) begin
                line_q <= ICON_ROW;
                ptr_q  <= ICON_ROW;
            end else begin
                line_q <= (line_q == LAST_DOT) ? '0 : line_q + 1'b1;
                ptr_q  <= ptr_q + 1'b1;
            end
        end
    end

    assign row_addr  = line_q;
    assign com_ptr   = ptr_q;
    assign row_valid = (st_q == ST_SCAN) || (st_q == ST_ICON);
endmodule

// File: rtl/lsd_m_gen.sv
module lsd_m_gen #(
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    input  logic          cl_step,
    input  logic          line_mode,
    input  logic [MW-1:0] line_n,
    output logic          m_pol
);
    logic [MW-1:0] cnt_q;
    logic [MW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            m_pol <= 1'b0;
        end else if (frame_sync) begin
            cnt_q <= '0;
            if (!line_mode) m_pol <= ~m_pol;
        end else if (cl_step && line_mode) begin
            if (cnt_inc >= {1'b0, line_n}) begin
                cnt_q <= '0;
                m_pol <= ~m_pol;
            end else begin
                cnt_q <= cnt_inc[MW-1:0];
            end
        end
    end
endmodule

// File: rtl/lsd_level_map.sv
module lsd_level_map
    import lsd_pkg::*;
#(
    parameter int SEG_N = 160,
    parameter int COM_N = 105,
    parameter int LW    = 7
) (
    input  logic [SEG_N-1:0]       seg_data,
    input  logic                   m_pol,
    input  logic                   disp_on,
    input  logic                   reverse_on,
    input  logic                   all_on,
    input  logic                   power_save,
    input  logic                   row_valid,
    input  logic [LW-1:0]          com_ptr,
    output logic [SEG_N*LVL_W-1:0] seg_lvl,
    output logic [COM_N*LVL_W-1:0] com_lvl
);
    for (genvar s = 0; s < SEG_N; s++) begin : g_seg
        logic eff;
        lvl_e lv;
        always_comb begin
            if (!disp_on)    eff = 1'b0;
            else if (all_on) eff = 1'b1;
            else             eff = seg_data[s] ^ reverse_on;
            if (power_save)  lv = LV_VSS;
            else if (eff)    lv = m_pol ? LV_V0 : LV_VSS;
            else             lv = m_pol ? LV_V2 : LV_V3;
        end
        assign seg_lvl[s*LVL_W +: LVL_W] = lv;
    end

    for (genvar c = 0; c < COM_N; c++) begin : g_com
        logic sel;
        lvl_e lv;
        always_comb begin
            sel = disp_on && row_valid && (com_ptr == LW'(c));
            if (power_save) lv = LV_VSS;
            else if (sel)   lv = m_pol ? LV_VSS : LV_V0;
            else            lv = m_pol ? LV_V1 : LV_V4;
        end
        assign com_lvl[c*LVL_W +: LVL_W] = lv;
    end
endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
    import lsd_pkg::*;
#(
    parameter int DOT_ROWS = 104,
    parameter int SEG_N    = 160,
    parameter int MW       = 4,
    localparam int COM_N   = DOT_ROWS + 1,
    localparam int LW      = $clog2(DOT_ROWS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_clk,
    input  logic                   frame_sync,
    input  logic                   start_wr,
    input  logic [LW-1:0]          start_val,
    input  logic                   disp_on,
    input  logic                   reverse_on,
    input  logic                   all_on,
    input  logic                   power_save,
    input  logic                   m_line_mode,
    input  logic [MW-1:0]          m_line_n,
    input  logic [SEG_N-1:0]       seg_data,
    output logic [LW-1:0]          row_addr,
    output logic                   row_valid,
    output logic [LW-1:0]          com_ptr,
    output logic                   m_pol,
    output logic [SEG_N*LVL_W-1:0] seg_lvl,
    output logic [COM_N*LVL_W-1:0] com_lvl
);
    logic cl_step;

    lsd_scan_seq #(.DOT_ROWS(DOT_ROWS), .LW(LW)) u_seq (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .frame_sync(frame_sync),
        .start_wr(start_wr), .start_val(start_val), .row_addr(row_addr),
        .com_ptr(com_ptr), .row_valid(row_valid), .cl_step(cl_step)
    );

    lsd_m_gen #(.MW(MW)) u_mgen (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .cl_step(cl_step),
        .line_mode(m_line_mode), .line_n(m_line_n), .m_pol(m_pol)
    );

    lsd_level_map #(.SEG_N(SEG_N), .COM_N(COM_N), .LW(LW)) u_map (
        .seg_data(seg_data), .m_pol(m_pol), .disp_on(disp_on),
        .reverse_on(reverse_on), .all_on(all_on), .power_save(power_save),
        .row_valid(row_valid), .com_ptr(com_ptr),
        .seg_lvl(seg_lvl), .com_lvl(com_lvl)
    );
endmodule

// File: rtl/lsd_scan_chk.sv
module lsd_scan_chk #(
    parameter int DOT_ROWS = 104,
    parameter int SEG_N    = 160,
    parameter int COM_N    = 105,
    parameter int LW       = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 line_clk,
    input logic                 frame_sync,
    input logic                 power_save,
    input logic                 m_line_mode,
    input logic [LW-1:0]        row_addr,
    input logic                 row_valid,
    input logic [LW-1:0]        com_ptr,
    input logic                 m_pol,
    input logic [SEG_N*3-1:0]   seg_lvl,
    input logic [COM_N*3-1:0]   com_lvl
);
    localparam logic [LW-1:0] LAST_DOT = LW'(DOT_ROWS - 1);
    localparam logic [LW-1:0] ICON_ROW = LW'(DOT_ROWS);

    p_frame_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (row_valid && com_ptr == '0));

    p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_clk && !frame_sync && row_valid && com_ptr < LAST_DOT) |=>
        (row_valid && com_ptr == $past(com_ptr) + 1'b1 &&
         row_addr == (($past(row_addr) == LAST_DOT) ? '0 : $past(row_addr) + 1'b1)));

    p_icon_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && com_ptr == ICON_ROW) |-> (row_addr == ICON_ROW));

    p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |-> (com_ptr <= ICON_ROW));

    p_all_vss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        power_save |-> (seg_lvl == '0 && com_lvl == '0));

    p_m_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && !m_line_mode) |=> (m_pol != $past(m_pol)));

    p_m_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && !line_clk) |=> $stable(m_pol));
endmodule

bind lcd_scan_drive lsd_scan_chk #(
    .DOT_ROWS(DOT_ROWS), .SEG_N(SEG_N), .COM_N(COM_N), .LW(LW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .frame_sync(frame_sync),
    .power_save(power_save), .m_line_mode(m_line_mode), .row_addr(row_addr),
    .row_valid(row_valid), .com_ptr(com_ptr), .m_pol(m_pol),
    .seg_lvl(seg_lvl), .com_lvl(com_lvl)
);

// File: tb/lcd_scan_drive_tb_top.sv
`timescale 1ns/1ps
module lcd_scan_drive_tb_top;
    localparam int ROWS = 104;
    localparam int SEGS = 160;
    localparam int COMS = 105;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_clk = 0, frame_sync = 0, start_wr = 0;
    logic [6:0] start_val = '0;
    logic disp_on = 1, reverse_on = 0, all_on = 0, power_save = 0;
    logic m_line_mode = 0;
    logic [3:0] m_line_n = '0;
    logic [SEGS-1:0] seg_data = '0;
    logic [6:0] row_addr, com_ptr;
    logic row_valid, m_pol;
    logic [SEGS*3-1:0] seg_lvl;
    logic [COMS*3-1:0] com_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    lcd_scan_drive dut_i (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .frame_sync(frame_sync),
        .start_wr(start_wr), .start_val(start_val), .disp_on(disp_on),
        .reverse_on(reverse_on), .all_on(all_on), .power_save(power_save),
        .m_line_mode(m_line_mode), .m_line_n(m_line_n), .seg_data(seg_data),
        .row_addr(row_addr), .row_valid(row_valid), .com_ptr(com_ptr),
        .m_pol(m_pol), .seg_lvl(seg_lvl), .com_lvl(com_lvl)
    );

    typedef struct {
        string tag;
        int    row;
        int    ptr;
        bit    vld;
        bit    m;
    } exp_t;

    exp_t exp_q[$];

    // reference model of the requirements
    int mdl_start = 0, mdl_row = 0, mdl_ptr = 0, mdl_st = 0, mdl_mc = 0;
    bit mdl_vld = 0, mdl_m = 0;

    task automatic chk(string tag, int got, int expv);
        n_tests++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " row_addr"},  row_addr,  e.row);
            chk({e.tag, " com_ptr"},   com_ptr,   e.ptr);
            chk({e.tag, " row_valid"}, row_valid, e.vld);
            chk({e.tag, " m_pol"},     m_pol,     e.m);
        end
    end

    // driver: one-cycle stimulus, then model update and push
    task automatic drive(string tag, bit fs, bit cl, bit wr, int val);
        exp_t e;
        int nstart;
        @(posedge clk); #1;
        frame_sync = fs; line_clk = cl; start_wr = wr; start_val = 7'(val);
        @(posedge clk); #1;
        frame_sync = 0; line_clk = 0; start_wr = 0;
        nstart = (wr && val < ROWS) ? val : mdl_start;
        if (fs) begin
            mdl_row = mdl_start; mdl_ptr = 0; mdl_vld = 1; mdl_st = 1;
            if (!m_line_mode) mdl_m = ~mdl_m; else mdl_mc = 0;
        end else if (cl && mdl_st != 0) begin
            if (mdl_st == 1) begin
                if (mdl_ptr == ROWS - 1) begin
                    mdl_st = 2; mdl_ptr = ROWS; mdl_row = ROWS;
                end else begin
                    mdl_ptr++; mdl_row = (mdl_row == ROWS - 1) ? 0 : mdl_row + 1;
                end
            end else if (mdl_st == 2) begin
                mdl_st = 3; mdl_vld = 0;
            end
            if (m_line_mode) begin
                if (mdl_mc + 1 >= int'(m_line_n)) begin mdl_mc = 0; mdl_m = ~mdl_m; end
                else mdl_mc++;
            end
        end
        mdl_start = nstart;
        e.tag = tag; e.row = mdl_row; e.ptr = mdl_ptr; e.vld = mdl_vld; e.m = mdl_m;
        exp_q.push_back(e);
    endtask

    function automatic int seg_exp(bit d, bit m, bit on, bit rev, bit all, bit ps);
        bit eff;
        if (ps) return 0;
        eff = !on ? 1'b0 : (all ? 1'b1 : d ^ rev);
        if (eff) return m ? 5 : 0;
        return m ? 3 : 2;
    endfunction

    task automatic lvl_checks(string tag);
        int idx[3] = '{0, 1, SEGS - 1};
        int rows[2] = '{mdl_ptr, (mdl_ptr + 7) % COMS};
        @(negedge clk);
        foreach (idx[k]) begin
            int i = idx[k];
            chk({tag, " seg"}, seg_lvl[i*3 +: 3],
                seg_exp(seg_data[i], mdl_m, disp_on, reverse_on, all_on, power_save));
        end
        foreach (rows[k]) begin
            int r = rows[k];
            bit sel = disp_on && mdl_vld && (r == mdl_ptr);
            int ex = power_save ? 0 : (sel ? (mdl_m ? 0 : 5) : (mdl_m ? 4 : 1));
            chk({tag, " com"}, com_lvl[r*3 +: 3], ex);
        end
    endtask

    task automatic set_modes(bit on, bit rev, bit all, bit ps);
        @(posedge clk); #1;
        disp_on = on; reverse_on = rev; all_on = all; power_save = ps;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13 reset state (reset still held)
        chk("R13 row_valid", row_valid, 0);
        chk("R13 row_addr", row_addr, 0);
        chk("R13 com_ptr", com_ptr, 0);
        chk("R13 m_pol", m_pol, 0);
        rst_n = 1;

        drive("R1 write 10", 0, 0, 1, 10);
        drive("R2 first frame", 1, 0, 0, 0);
        for (int k = 0; k < ROWS - 1; k++) drive("R3 dot step", 0, 1, 0, 0);
        drive("R4 icon row", 0, 1, 0, 0);
        drive("R4 after icon", 0, 1, 0, 0);
        drive("R4 wait idle", 0, 1, 0, 0);

        drive("R1 write 120 ignored", 0, 0, 1, 120);
        drive("R1 write 104 ignored", 0, 0, 1, 104);
        drive("R1 R11 frame keeps 10", 1, 0, 0, 0);

        seg_data = '0;
        seg_data[0] = 1'b1;
        seg_data[SEGS-1] = 1'b1;
        for (int p = 0; p < 2; p++) begin
            set_modes(1, 0, 0, 0); lvl_checks("R5 R9 normal");
            set_modes(1, 1, 0, 0); lvl_checks("R6 reverse");
            set_modes(1, 1, 1, 0); lvl_checks("R7 all on over reverse");
            set_modes(0, 0, 0, 0); lvl_checks("R8 display off");
            set_modes(1, 1, 1, 1); lvl_checks("R10 power save");
            set_modes(1, 0, 0, 0);
            drive("R11 frame toggles", 1, 0, 0, 0);
        end
        for (int k = 0; k < 5; k++) drive("R3 R9 step", 0, 1, 0, 0);
        lvl_checks("R9 selected row moved");

        // frame sync, line pulse and write in one cycle
        drive("R2 same-cycle frame", 1, 1, 1, 50);
        drive("R2 next pulse", 0, 1, 0, 0);
        drive("R2 new start applies", 1, 0, 0, 0);

        drive("R3 write 100", 0, 0, 1, 100);
        drive("R3 frame at 100", 1, 0, 0, 0);
        for (int k = 0; k < 6; k++) drive("R3 wrap 103 to 0", 0, 1, 0, 0);

        // line-based polarity
        @(posedge clk); #1; m_line_mode = 1; m_line_n = 4'd3;
        drive("R12 frame no toggle", 1, 0, 0, 0);
        for (int k = 0; k < 7; k++) drive("R12 every 3 lines", 0, 1, 0, 0);
        drive("R12 frame with pulse clears", 1, 1, 0, 0);
        for (int k = 0; k < 3; k++) drive("R12 count restarted", 0, 1, 0, 0);
        @(posedge clk); #1; m_line_n = 4'd0;
        for (int k = 0; k < 3; k++) drive("R12 n=0 every line", 0, 1, 0, 0);
        for (int k = 0; k < 3; k++) drive("R12 idle cycles", 0, 0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule